// File: doc/BRIEF.md
# Two-Beat Burst DDR SRAM Command Controller

This block is the bus-master side of a double-data-rate synchronous SRAM link. Each access moves two words. A user request carries an address, a write flag and two write words, and it is taken through a ready/valid handshake. The block then issues one command per memory clock cycle: a cycle-start strobe (active low), a read/write select, and the address. It drives the write words on the two clock phases of the following cycle. For a read, it captures the two returning words one and a half cycles after the command and hands both back together with a one-cycle valid pulse.

The design runs on a fabric clock at twice the memory clock rate. Each memory clock cycle is split into a K-high half and a K#-high half, and `memKRise` marks the K-high half. After reset, and again after a clock-interruption event, the block will not issue commands until the memory's delay-locked loop has had a set number of stable memory cycles. A bypass input skips this wait when that loop is switched off. Whenever no command goes out, the block emits a no-operation cycle.

Top module: `ddr2b_ctrl_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `memLdN` is 1, `memDqOe` is 0, `rdValid` is 0 and `reqReady` is 0.
- R2: With `dllBypass` low, `reqReady` stays 0 until LOCK_CYCLES memory cycles have passed since reset. Counting fabric cycles after reset from 0, it first rises on cycle 2*LOCK_CYCLES. With `dllBypass` high, the wait is skipped.
- R3: A one-cycle pulse on `lockRestart` drops `reqReady` on the next cycle and restarts the full LOCK_CYCLES wait.
- R4: `reqReady` is only ever high in a K#-high half (`memKRise`=0), so at most one request is accepted per memory cycle. An accepted request drives `memLdN`=0 for the whole next memory cycle, with `memRwN`=0 for a write and 1 for a read.
- R5: During the K-high half of a command cycle, `memAddr` is the request address. During the K#-high half, it is that address with bit 0 inverted.
- R6: For a write issued in cycle c, `memDqOut` carries word 0 in the K-high half of cycle c+1 and word 1 in its K#-high half. `memDqOe` is 1 during exactly those two fabric cycles, unless another write follows back to back.
- R7: For a read whose command starts in fabric cycle f, `memDqIn` is taken as word 0 at the end of fabric cycle f+3 and as word 1 at the end of f+4. `rdValid` is 1 for the single cycle f+5, with word 0 on `rdData0` and word 1 on `rdData1`.
- R8: A write request that arrives directly after a read command is held off for one memory cycle, and a no-operation cycle is inserted, so that write beats never share the bus with returning read beats. A read directly after a write is accepted back to back.
- R9: In any memory cycle with no accepted request, `memLdN` is 1 and `memDqOe` stays 0 unless a previous write's beats are under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, twice the memory clock rate |
| rst | input | 1 | Synchronous reset, active high |
| dllBypass | input | 1 | Memory lock loop disabled; skip the lock wait |
| lockRestart | input | 1 | Clock-interruption event; restart the lock wait |
| reqValid | input | 1 | User request present |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Burst base address |
| reqWdata0 | input | DATA_W | Write word for the base address |
| reqWdata1 | input | DATA_W | Write word for the partner address |
| rdValid | output | 1 | Read words valid, one-cycle pulse |
| rdData0 | output | DATA_W | Read word from the base address |
| rdData1 | output | DATA_W | Read word from the partner address |
| memKRise | output | 1 | High during the K-high half of each memory cycle |
| memLdN | output | 1 | Cycle-start strobe, active low |
| memRwN | output | 1 | Read/write select, 0 = write |
| memAddr | output | ADDR_W | Memory address, bit 0 flipped in the second half |
| memDqOut | output | DATA_W | Write data toward the memory |
| memDqOe | output | 1 | Write data output enable |
| memDqIn | input | DATA_W | Read data from the memory |

## Verification
The hardest case to reach is a write request that arrives in the very cycle after a read command. The turnaround rule must then hold the write back, or the write beats and the returning read beats collide on the shared bus. The bench issues a read and, in the command cycle, raises a write request. It then checks that ready stays low for one memory cycle and that a no-operation cycle appears. Next it drives the read beats and confirms the write beats follow after them. The opposite order, a read directly after a write, is run as well to show that no gap is inserted there.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic kHigh;       // current fabric cycle is the K-high half
    logic issue;       // load a new command at this edge
    logic issueWrite;  // the new command is a write
  } dpStrb_t;
endpackage

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl
  import ddr2b_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    dllBypass,
  input  logic    lockRestart,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output dpStrb_t strb
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOCK_MAX = CNT_W'(LOCK_CYCLES);

  logic             phase;        // 0 = K-high half, 1 = K#-high half
  logic [CNT_W-1:0] lockCnt;
  logic             lastWasRead;  // command on the bus this memory cycle is a read
  logic             locked;
  logic             accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= 1'b0;
      lockCnt     <= '0;
      lastWasRead <= 1'b0;
    end else begin
      phase <= ~phase;
      if (lockRestart)
        lockCnt <= '0;
      else if (phase && lockCnt != LOCK_MAX)
        lockCnt <= lockCnt + 1'b1;
      if (phase)
        lastWasRead <= accept && !reqWrite;
    end
  end

  assign locked   = dllBypass || (lockCnt == LOCK_MAX);
  assign reqReady = locked && phase && !lockRestart && !(lastWasRead && reqWrite);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strb.kHigh      = ~phase;
    strb.issue      = accept;
    strb.issueWrite = reqWrite;
  end

  // R3: a restart event blocks acceptance on the following cycle
  a_r3_restart_blocks: assert property (@(posedge clk) disable iff (rst)
    (lockRestart && !dllBypass) |=> !reqReady);

  // R4: acceptance only at the end of a memory cycle
  a_r4_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
    accept |=> !reqReady);
endmodule

// File: rtl/ddr2b_datapath.sv
module ddr2b_datapath
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrb_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata0,
  input  logic [DATA_W-1:0] reqWdata1,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData0,
  output logic [DATA_W-1:0] rdData1,
  output logic              memKRise,
  output logic              memLdN,
  output logic              memRwN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);
  localparam int RD_LAT = 3;  // fabric stages from command end to last beat

  logic              ldN, rwN;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wd0Q, wd1Q, beat2Q, dqQ;
  logic              oeQ;
  logic [RD_LAT-1:0] rdPipe;
  logic [DATA_W-1:0] rd0Q, rd1Q;
  logic              validQ;
  logic              curWrite, curRead;

  assign curWrite = !ldN && !rwN;
  assign curRead  = !ldN &&  rwN;

  always_ff @(posedge clk) begin
    if (rst) begin
      ldN    <= 1'b1;
      rwN    <= 1'b1;
      addrQ  <= '0;
      wd0Q   <= '0;
      wd1Q   <= '0;
      beat2Q <= '0;
      dqQ    <= '0;
      oeQ    <= 1'b0;
      rdPipe <= '0;
      rd0Q   <= '0;
      rd1Q   <= '0;
      validQ <= 1'b0;
    end else begin
      // read return: beats land in the 4th and 5th fabric cycles after command start
      rdPipe <= {rdPipe[RD_LAT-2:0], (!strb.kHigh && curRead)};
      if (rdPipe[1]) rd0Q <= memDqIn;
      if (rdPipe[2]) rd1Q <= memDqIn;
      validQ <= rdPipe[2];

      if (!strb.kHigh) begin
        // end of a memory cycle: load the next command or a NOP
        ldN <= !strb.issue;
        if (strb.issue) begin
          rwN   <= !strb.issueWrite;
          addrQ <= reqAddr;
          wd0Q  <= reqWdata0;
          wd1Q  <= reqWdata1;
        end
        // write beats follow one memory cycle after the command
        oeQ <= curWrite;
        if (curWrite) begin
          dqQ    <= wd0Q;
          beat2Q <= wd1Q;
        end
      end else if (oeQ) begin
        dqQ <= beat2Q;
      end
    end
  end

  assign memKRise = strb.kHigh;
  assign memLdN   = ldN;
  assign memRwN   = rwN;
  assign memAddr  = strb.kHigh ? addrQ : {addrQ[ADDR_W-1:1], ~addrQ[0]};
  assign memDqOut = dqQ;
  assign memDqOe  = oeQ;
  assign rdValid  = validQ;
  assign rdData0  = rd0Q;
  assign rdData1  = rd1Q;

  // R4: a command in the K-high half comes from an acceptance on the edge before
  a_r4_cmd_from_accept: assert property (@(posedge clk) disable iff (rst)
    (!ldN && strb.kHigh) |-> $past(strb.issue));

  // R4: the strobe holds across both halves of a memory cycle
  a_r4_cmd_held: assert property (@(posedge clk) disable iff (rst)
    strb.kHigh |=> $stable(ldN));

  // R6: the output enable only rises after a write command
  a_r6_oe_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(oeQ) |-> $past(curWrite));

  // R8: write beats never overlap returning read beats
  a_r8_no_bus_clash: assert property (@(posedge clk) disable iff (rst)
    !(oeQ && (rdPipe[1] || rdPipe[2])));
endmodule

// File: rtl/ddr2b_ctrl_top.sv
module ddr2b_ctrl_top
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 18,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dllBypass,
  input  logic              lockRestart,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata0,
  input  logic [DATA_W-1:0] reqWdata1,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData0,
  output logic [DATA_W-1:0] rdData1,
  output logic              memKRise,
  output logic              memLdN,
  output logic              memRwN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);
  dpStrb_t strb;

  ddr2b_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .dllBypass(dllBypass), .lockRestart(lockRestart),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReady(reqReady), .strb(strb)
  );

  ddr2b_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb),
    .reqAddr(reqAddr), .reqWdata0(reqWdata0), .reqWdata1(reqWdata1),
    .rdValid(rdValid), .rdData0(rdData0), .rdData1(rdData1),
    .memKRise(memKRise), .memLdN(memLdN), .memRwN(memRwN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );
endmodule

// File: tb/ddr2b_ctrl_top_tb.sv
module ddr2b_ctrl_top_tb_top;
  localparam int AW = 20;
  localparam int DW = 18;
  localparam int LK = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dllBypass = 1'b0, lockRestart = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata0 = '0, reqWdata1 = '0;
  logic [DW-1:0] memDqIn = '0;
  logic reqReady, rdValid, memKRise, memLdN, memRwN, memDqOe;
  logic [DW-1:0] rdData0, rdData1, memDqOut;
  logic [AW-1:0] memAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  ddr2b_ctrl_top #(.ADDR_W(AW), .DATA_W(DW), .LOCK_CYCLES(LK)) dut_i (
    .clk(clk), .rst(rst), .dllBypass(dllBypass), .lockRestart(lockRestart),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata0(reqWdata0), .reqWdata1(reqWdata1), .rdValid(rdValid),
    .rdData0(rdData0), .rdData1(rdData1), .memKRise(memKRise), .memLdN(memLdN),
    .memRwN(memRwN), .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic nx;
    @(negedge clk);
  endtask

  // raise a request and return at the negedge of cycle c (command on bus)
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d0, logic [DW-1:0] d1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata0 = d0; reqWdata1 = d1;
    nx();
    while (!reqReady) nx();
    nx();
    reqValid = 1'b0;
  endtask

  task automatic t_reset;
    nx();
    check("R1 ldN in reset", memLdN, 1);
    check("R1 oe in reset", memDqOe, 0);
    check("R1 valid in reset", rdValid, 0);
    check("R1 ready in reset", reqReady, 0);
  endtask

  task automatic t_lock;
    int k = 0;
    rst = 1'b0;
    nx();
    check("R1 ldN after reset", memLdN, 1);
    while (!reqReady && k < 3000) begin nx(); k++; end
    check("R2 lock wait length", k, 2 * LK);
  endtask

  task automatic t_write(logic [AW-1:0] a, logic [DW-1:0] d0, logic [DW-1:0] d1);
    issue(1'b1, a, d0, d1);
    check("R4 write strobe", {memKRise, memLdN, memRwN}, 3'b100);
    check("R5 base addr", memAddr, a);
    nx();
    check("R5 partner addr", memAddr, {a[AW-1:1], ~a[0]});
    check("R4 strobe held", memLdN, 0);
    nx();
    check("R6 beat0", {memKRise, memDqOe, memDqOut}, {2'b11, d0});
    nx();
    check("R6 beat1", {memDqOe, memDqOut}, {1'b1, d1});
    nx();
    check("R6 oe release", memDqOe, 0);
    check("R9 nop strobe", memLdN, 1);
  endtask

  task automatic t_read(logic [AW-1:0] a, logic [DW-1:0] v0, logic [DW-1:0] v1);
    issue(1'b0, a, '0, '0);
    check("R4 read strobe", {memKRise, memLdN, memRwN}, 3'b101);
    check("R5 read base addr", memAddr, a);
    nx();
    check("R5 read partner addr", memAddr, {a[AW-1:1], ~a[0]});
    nx();
    nx(); memDqIn = v0;
    nx(); memDqIn = v1;
    nx(); memDqIn = '0;
    check("R7 read valid", rdValid, 1);
    check("R7 read words", {rdData0, rdData1}, {v0, v1});
    nx();
    check("R7 valid pulse", rdValid, 0);
  endtask

  task automatic t_rd_then_wr;
    issue(1'b0, 20'h00100, '0, '0);              // cycle c
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 20'h00201;
    reqWdata0 = 18'h2aaaa; reqWdata1 = 18'h15555;
    nx();                                        // c+1
    check("R8 write held after read", reqReady, 0);
    nx();                                        // c+2
    check("R8 nop inserted", memLdN, 1);
    nx(); memDqIn = 18'h01234;                   // c+3
    check("R8 write accepted late", reqReady, 1);
    nx(); memDqIn = 18'h04321;                   // c+4
    reqValid = 1'b0;
    check("R8 write cmd", {memLdN, memRwN}, 2'b00);
    check("R8 bus free", memDqOe, 0);
    nx(); memDqIn = '0;                          // c+5
    check("R7 read before write", {rdValid, rdData0, rdData1}, {1'b1, 18'h01234, 18'h04321});
    nx();                                        // c+6
    check("R6 late write beat0", {memDqOe, memDqOut}, {1'b1, 18'h2aaaa});
    nx();                                        // c+7
    check("R6 late write beat1", {memDqOe, memDqOut}, {1'b1, 18'h15555});
    nx();
  endtask

  task automatic t_wr_then_rd;
    issue(1'b1, 20'h00300, 18'h00aa1, 18'h00bb2);  // c
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 20'h00401;
    nx();                                           // c+1
    check("R8 read back to back", reqReady, 1);
    nx();                                           // c+2
    reqValid = 1'b0;
    check("R8 read cmd", {memLdN, memRwN}, 2'b01);
    check("R6 beat0 under read", {memDqOe, memDqOut}, {1'b1, 18'h00aa1});
    nx();                                           // c+3
    check("R6 beat1 under read", {memDqOe, memDqOut}, {1'b1, 18'h00bb2});
    nx();                                           // c+4
    check("R6 release", memDqOe, 0);
    nx(); memDqIn = 18'h3c3c3;                      // c+5
    nx(); memDqIn = 18'h0f0f0;                      // c+6
    nx(); memDqIn = '0;                             // c+7
    check("R7 read after write", {rdValid, rdData0, rdData1}, {1'b1, 18'h3c3c3, 18'h0f0f0});
  endtask

  task automatic t_nop;
    int bad = 0;
    reqValid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      nx();
      if (memLdN !== 1'b1 || memDqOe !== 1'b0) bad++;
    end
    check("R9 idle nops", bad, 0);
  endtask

  task automatic t_restart;
    int k = 0;
    lockRestart = 1'b1;
    nx();
    lockRestart = 1'b0;
    check("R3 ready dropped", reqReady, 0);
    while (!reqReady && k < 3000) begin nx(); k++; end
    check("R3 rerun wait", (k >= 2 * LK - 4 && k <= 2 * LK + 2), 1);
  endtask

  task automatic t_bypass;
    int k = 0;
    lockRestart = 1'b1;
    nx();
    lockRestart = 1'b0;
    dllBypass   = 1'b1;
    while (!reqReady && k < 10) begin nx(); k++; end
    check("R2 bypass skips wait", (k <= 2), 1);
    dllBypass = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (3) nx();
    t_reset();
    t_lock();
    t_write(20'h00010, 18'h11111, 18'h22222);
    t_write(20'h00021, 18'h33333, 18'h04444);
    t_read(20'h00030, 18'h0abcd, 18'h1dcba);
    t_read(20'h00041, 18'h00001, 18'h3fffe);
    t_rd_then_wr();
    t_wr_then_rd();
    t_nop();
    t_restart();
    t_bypass();
    t_write(20'h00050, 18'h05a5a, 18'h0a5a5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule